// File: doc/BRIEF.md
# I2C Target Address Front End

This block is the responder side of a two-wire serial bus for a device that never acts as bus master. It takes the raw clock and data lines and resynchronises them to the system clock. It removes short pulses from both lines and then detects clock edges and bus framing conditions. After a START it collects an address byte and compares its upper seven bits with a programmable device address. On a hit it pulls the data line low to acknowledge. From then on it either delivers write bytes to a byte-wide register port or fetches bytes from that port and shifts them out to the master.

The data line is open-drain. The block only outputs a pull-low enable, and the pad or bench forms the wired-AND bus. Every 7-bit address value, reserved or not, is compared literally. The one exception is the all-zero address with a write direction, which is always refused. After any refusal the block keeps off the bus until the next START or STOP.

Top module: `i2c_tgt`

## Requirements
- R1: The block never drives the data line high; `sda_oe_o` high means pull low. `sda_oe_o` changes only while the filtered clock is low.
- R2: A START (data falling while clock high) or a STOP (data rising while clock high) is honoured in every state. It releases the data line within one cycle and restarts the address phase (START) or returns to idle (STOP), including in the middle of a byte.
- R3: Each line passes through a two-flop synchroniser and a filter that only follows three equal consecutive samples. A clock pulse of two system cycles or less has no effect on received data.
- R4: Bits arrive MSB first. The first byte after a START carries the address in bits 7..1 and the direction in bit 0 (1 = read). When the address equals `dev_addr_i`, the block pulls the data line low for the ninth clock pulse. This holds for every 7-bit value, including 0000000 with a read direction.
- R5: When the address does not match, the data line stays released for the acknowledge bit and for all following bytes, and no write strobe occurs until the next START or STOP.
- R6: Address 0000000 with a write direction is refused even when `dev_addr_i` is zero. All later bytes are refused until a repeated START or a STOP, after which a normal transfer works.
- R7: In a write transfer, each received data byte raises `wr_valid_o` for exactly one cycle with the byte on `wr_data_o`, and the block acknowledges every byte.
- R8: In a read transfer, the block captures `rd_data_i` after the address acknowledge and after each master acknowledge, and pulses `rd_req_o` for one cycle per capture. It shifts the byte out MSB first. After a master NACK it releases the data line for the remaining clocks.
- R9: An address of the form 11110XX is treated as a plain 7-bit address. With `dev_addr_i` = 1111010 a write to that address is acknowledged and its data delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| dev_addr_i | input | 7 | Programmable device address |
| rd_data_i | input | 8 | Byte to send; sampled in the cycle before `rd_req_o` |
| sda_oe_o | output | 1 | Pull data line low when high |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_data_o | output | 8 | Received write byte |
| rd_req_o | output | 1 | One-cycle pulse after `rd_data_i` was captured |

## Verification
The hardest situations to reach are the ones where the master changes its mind partway through a frame. These are a repeated START four bits into a data byte, and continued clocking after a NACK has put the block into its idle-until-framing state. The bench reaches them with a bit-level master model. It can break off a byte after any bit, issue a new START while the clock is low, and insert two-cycle clock spikes inside a bit's low phase. A scoreboard compares every write strobe against the bytes that should have been accepted, so any strobe that leaks out of an ignored phase is caught.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;

  localparam logic [ADDR_W-1:0] GEN_CALL_ADDR = '0;
endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
  parameter int unsigned SYNC_W = 2,
  parameter int unsigned WIN_W  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [SYNC_W-1:0] sync_q;
  logic [WIN_W-1:0]  win_q;
  logic              q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      q_q    <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_W-2:0], d_i};
      win_q  <= {win_q[WIN_W-2:0], sync_q[SYNC_W-1]};
      if (&win_q)       q_q <= 1'b1;
      else if (~|win_q) q_q <= 1'b0;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // framing only counts while the clock stays high across the data edge
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  tgt_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q, wdata_q;
  logic              oe_q, wv_q, rr_q, rw_q, mack_q;
  logic              gen_call, addr_hit;

  assign gen_call = (sh_q[DATA_W-1:1] == GEN_CALL_ADDR) && !sh_q[0];
  assign addr_hit = (sh_q[DATA_W-1:1] == dev_addr_i) && !gen_call;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      wdata_q <= '0;
      oe_q    <= 1'b0;
      wv_q    <= 1'b0;
      rr_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      wv_q <= 1'b0;
      rr_q <= 1'b0;
      if (start_i) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_i) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              rw_q <= sh_q[0];
              if (addr_hit) begin
                st_q <= ST_ADDR_ACK;
                oe_q <= 1'b1;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                st_q <= ST_RD;
                sh_q <= rd_data_i;
                oe_q <= ~rd_data_i[DATA_W-1];
                rr_q <= 1'b1;
              end else begin
                st_q <= ST_WR;
                oe_q <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              wdata_q <= sh_q;
              wv_q    <= 1'b1;
              oe_q    <= 1'b1;
              st_q    <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (cnt_q == CNT_LAST) begin
                oe_q <= 1'b0;
                st_q <= ST_RD_ACK;
              end else begin
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                oe_q  <= ~sh_q[DATA_W-2];
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              cnt_q <= '0;
              if (mack_q) begin
                st_q <= ST_RD;
                sh_q <= rd_data_i;
                oe_q <= ~rd_data_i[DATA_W-1];
                rr_q <= 1'b1;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_valid_o = wv_q;
  assign wr_data_o  = wdata_q;
  assign rd_req_o   = rr_q;
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o
);
  logic [1:0] raw, flt;
  logic       scl_flt, sda_flt;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  assign raw = {scl_i, sda_i};

  for (genvar i = 0; i < 2; i++) begin : g_line
    i2c_tgt_filt #(.SYNC_W(2), .WIN_W(3)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[i]),
      .q_o   (flt[i])
    );
  end

  assign scl_flt = flt[1];
  assign sda_flt = flt[0];

  i2c_tgt_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_flt),
    .sda_i     (sda_flt),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  i2c_tgt_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_ev),
    .stop_i    (stop_ev),
    .sda_i     (sda_flt),
    .dev_addr_i(dev_addr_i),
    .rd_data_i (rd_data_i),
    .sda_oe_o  (sda_oe_o),
    .wr_valid_o(wr_valid_o),
    .wr_data_o (wr_data_o),
    .rd_req_o  (rd_req_o)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe_o,
  input logic wr_valid_o,
  input logic rd_req_o
);
  a_r1_oe_moves_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_f);

  a_r2_framing_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ev || stop_ev) |=> !sda_oe_o);

  a_r7_wr_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  a_r8_rd_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  a_r8_no_mixed_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_valid_o));
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_f     (scl_flt),
  .start_ev  (start_ev),
  .stop_ev   (stop_ev),
  .sda_oe_o  (sda_oe_o),
  .wr_valid_o(wr_valid_o),
  .rd_req_o  (rd_req_o)
);

// File: tb/tb_i2c_tgt.sv
module tb_i2c_tgt;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_bus;
  logic [6:0] dev_addr = 7'h2A;
  logic [7:0] rd_data = 8'h00;
  logic       sda_oe, wr_valid, rd_req;
  logic [7:0] wr_data;

  int errors = 0, checks = 0, rd_reqs = 0, r1_viol = 0;
  logic [7:0] exp_q[$];
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_tgt dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .dev_addr_i(dev_addr),
    .rd_data_i (rd_data),
    .sda_oe_o  (sda_oe),
    .wr_valid_o(wr_valid),
    .wr_data_o (wr_data),
    .rd_req_o  (rd_req)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: write strobes against scoreboard, read requests, R1 drive timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write", int'(wr_data), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(wr_data == e, "R7 write data", int'(wr_data), int'(e));
        end
      end
      if (rd_req) rd_reqs++;
      if (sda_oe !== prev_oe && scl_m) r1_viol++;
      prev_oe = sda_oe;
    end
  end

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_x(input logic b, input logic glitch, output logic got);
    sda_m = b;
    if (glitch) begin
      wq(3); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q - 5);
    end else wq();
    scl_m = 1'b1; wq(); got = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic byte_w(input logic [7:0] d, input logic glitch, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bit_x(d[i], glitch, g);
    bit_x(1'b1, 1'b0, g);
    ack = !g;
  endtask

  task automatic byte_r(input logic mack, input logic [7:0] next, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, 1'b0, g);
      d[i] = g;
    end
    rd_data = next;
    bit_x(!mack, 1'b0, g);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    wq(4);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0 && rd_req == 1'b0, "R1 reset outputs",
        int'({sda_oe, wr_valid, rd_req}), 0);
    rst_n = 1'b1;
    wq(4);

    // R4 + R7: addressed write, two bytes
    start_c();
    byte_w({7'h2A, 1'b0}, 1'b0, a); chk(a, "R4 address ack", a, 1);
    exp_q.push_back(8'hA5);
    byte_w(8'hA5, 1'b0, a); chk(a, "R7 data ack", a, 1);
    exp_q.push_back(8'h3C);
    byte_w(8'h3C, 1'b0, a); chk(a, "R7 data ack", a, 1);
    // R3: clock spikes inside each low phase
    exp_q.push_back(8'h81);
    byte_w(8'h81, 1'b1, a); chk(a, "R3 glitched byte ack", a, 1);
    stop_c();
    wq(4);

    // R5: mismatch
    start_c();
    byte_w({7'h2B, 1'b0}, 1'b0, a); chk(!a, "R5 mismatch nack", a, 0);
    byte_w(8'h11, 1'b0, a); chk(!a, "R5 later byte nack", a, 0);
    stop_c();
    wq(4);

    // R2: repeated START four bits into a data byte
    start_c();
    byte_w({7'h2A, 1'b0}, 1'b0, a);
    for (int i = 0; i < 4; i++) bit_x(1'b0, 1'b0, a);
    start_c();
    byte_w({7'h2A, 1'b0}, 1'b0, a); chk(a, "R2 ack after restart", a, 1);
    exp_q.push_back(8'h55);
    byte_w(8'h55, 1'b0, a); chk(a, "R2 data after restart", a, 1);
    stop_c();
    wq(4);

    // R8: read, master ACK then NACK, then extra clocks
    rd_reqs = 0;
    rd_data = 8'hC3;
    start_c();
    byte_w({7'h2A, 1'b1}, 1'b0, a); chk(a, "R8 read address ack", a, 1);
    byte_r(1'b1, 8'h5A, d); chk(d == 8'hC3, "R8 first byte", int'(d), 8'hC3);
    byte_r(1'b0, 8'h00, d); chk(d == 8'h5A, "R8 second byte", int'(d), 8'h5A);
    byte_r(1'b0, 8'h00, d); chk(d == 8'hFF, "R8 released after nack", int'(d), 8'hFF);
    stop_c();
    wq(4);
    chk(rd_reqs == 2, "R8 rd_req count", rd_reqs, 2);

    // R6: general call with dev_addr zero, then literal read of address zero
    dev_addr = 7'h00;
    wq(4);
    start_c();
    byte_w(8'h00, 1'b0, a); chk(!a, "R6 general call nack", a, 0);
    byte_w(8'h77, 1'b0, a); chk(!a, "R6 ignored byte", a, 0);
    rd_data = 8'h96;
    start_c();
    byte_w(8'h01, 1'b0, a); chk(a, "R4 zero address read ack", a, 1);
    byte_r(1'b0, 8'h00, d); chk(d == 8'h96, "R6 read after restart", int'(d), 8'h96);
    stop_c();
    wq(4);

    // R9: 11110XX address treated literally
    dev_addr = 7'h7A;
    wq(4);
    start_c();
    byte_w({7'h7A, 1'b0}, 1'b0, a); chk(a, "R9 11110XX ack", a, 1);
    exp_q.push_back(8'hE7);
    byte_w(8'hE7, 1'b0, a); chk(a, "R9 data ack", a, 1);
    stop_c();
    wq(8);

    chk(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);
    chk(r1_viol == 0, "R1 drive changes only with clock low", r1_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule